// File: doc/BRIEF.md
# Long-Burst SPI Master

This block is an SPI master that clocks out one unbroken burst of anywhere from one bit to a couple of thousand bits. The data moves through a 32-bit transmit FIFO and a 32-bit receive FIFO. Software writes the burst length minus one and sets a start bit in the control register; the transfer must first be primed by pushing words into the transmit FIFO. The master then pulls chip select low and shifts every bit MSB first in SPI mode 0, with SCLK at half the system clock. Chip select stays low across word boundaries. As each word completes, the block writes it into the receive FIFO. At the end it drops the busy/start bit and raises a sticky completion flag, which can also drive an interrupt line.

Burst lengths need not be whole multiples of 32. The remainder (bit count mod 32) is carried by the first word, right-aligned, and the full words follow. The first received word is right-aligned in the same way, with its unused upper bits set to zero. Lengths of the form 32n+1 are ordinary cases here. Their single leading bit is handled by the same word-sizing rule as any other remainder, so no receive word is ever duplicated.

A loopback mode ties the serial output to the serial input internally, so software can check the data path without a slave.

Top module: `lbspi_master`

## Requirements
- R1: A value L written to control bits [10:0] (register address 0) produces a burst of exactly L+1 rising SCLK edges. Chip select is released exactly once, after the last bit, with no release between words.
- R2: If the bit count N is not a multiple of 32, only the N mod 32 least significant bits of the first transmit word are sent, and the upper bits of that word are ignored. Every later word sends all 32 bits. All bits go out MSB first.
- R3: Writing control bit 16 = 1 starts a burst. Control bit 16 reads 1 while the burst runs and 0 after the last bit, and status bit 0 (address 1) is then 1. This holds for 1, 33, 65, 97 and 129 bits.
- R4: With loopback on (control bit 17), the receive FIFO (read at address 4) holds exactly the transmitted words, in order, with none duplicated. The leftover first word is right-aligned and zero-extended. The level register (address 2) then shows the transmit count [6:0] = 0 and the receive count [22:16] = ceil(N/32). Transmit words are written at address 3.
- R5: The interrupt output is high exactly while status bit 0 is 1 and the interrupt enable (control bit 18) is 1.
- R6: Writing 1 to status bit 0 clears it. If that write lands in the same cycle as a burst completing, the flag stays set.
- R7: Each FIFO is 64 words deep. A transmit write when the FIFO is full is dropped: the level stays at 64, status bit 2 reads 1, and the dropped word is never sent.
- R8: If a word completes while the receive FIFO is full, that word is discarded and the sticky overrun flag (status bit 1) is set. Writing 1 to status bit 1 clears the flag.
- R9: SCLK idles low. MOSI changes only while SCLK is low, and is stable across each rising edge, where the input is sampled.
- R10: After reset, chip select is high, SCLK and the interrupt are low, and the control, status and level registers read 0.
- R11: A control write made while a burst is running is ignored: the length, loopback and enable fields are unchanged, and no new burst is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_re_i | input | 1 | Register read strobe (pops the receive FIFO at address 4) |
| reg_rdata_o | output | 32 | Register read data, combinational |
| sclk_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two functions can act on the completion flag in the same clock edge: the burst setting it on the final falling SCLK edge, and a write-one-to-clear from software. The bench starts a one-bit burst and places the clear write three edges after the start write, which is the exact edge on which the last bit retires. The result is judged at the ports: the status flag must still read 1 and the interrupt must stay high. A second clear written on its own must then drop both.

// File: rtl/lbspi_pkg.sv
`timescale 1ns/1ps
package lbspi_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_LEVEL  = 3'd2,
    A_TXDATA = 3'd3,
    A_RXDATA = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_START_BIT = 16;
  localparam int unsigned CTRL_LOOP_BIT  = 17;
  localparam int unsigned CTRL_IRQEN_BIT = 18;

  localparam int unsigned STAT_DONE_BIT   = 0;
  localparam int unsigned STAT_OVR_BIT    = 1;
  localparam int unsigned STAT_TXFULL_BIT = 2;
  localparam int unsigned STAT_RXAVL_BIT  = 3;

  localparam int unsigned LVL_RX_LSB = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH
  } eng_state_e;
endpackage

// File: rtl/lbspi_fifo.sv
`timescale 1ns/1ps
module lbspi_fifo #(
  parameter  int unsigned WIDTH = 32,
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  full_push_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_o == CNT_W'(DEPTH)));

  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/lbspi_engine.sv
`timescale 1ns/1ps
module lbspi_engine
  import lbspi_pkg::*;
#(
  parameter  int unsigned LEN_W  = 11,
  localparam int unsigned BITS_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              loopback_i,
  input  logic              miso_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no
);
  eng_state_e        state_q;
  logic [WORD_W-1:0] tx_sr_q, rx_sr_q;
  logic [5:0]        wbits_q, word_bits;
  logic [BITS_W-1:0] rem_q, nbits;
  logic              miso_eff;

  assign nbits = {1'b0, len_i} + BITS_W'(1);
  // remaining bits mod 32 sizes the next word: only the first one can be short
  assign word_bits = (rem_q[4:0] == 5'd0) ? 6'd32 : {1'b0, rem_q[4:0]};
  assign miso_eff  = loopback_i ? tx_sr_q[WORD_W-1] : miso_i;

  assign tx_pop_o  = (state_q == ST_FETCH) && !tx_empty_i;
  assign rx_push_o = (state_q == ST_HIGH) && (wbits_q == 6'd1);
  assign rx_word_o = rx_sr_q;
  assign done_o    = (state_q == ST_HIGH) && (rem_q == BITS_W'(1));
  assign busy_o    = (state_q != ST_IDLE);
  assign sclk_o    = (state_q == ST_HIGH);
  assign cs_no     = (state_q == ST_IDLE);
  assign mosi_o    = tx_sr_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      wbits_q <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rem_q   <= nbits;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!tx_empty_i) begin
            tx_sr_q <= tx_word_i << (6'd32 - word_bits);
            rx_sr_q <= '0;
            wbits_q <= word_bits;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso_eff};
          state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
          wbits_q <= wbits_q - 6'd1;
          rem_q   <= rem_q - BITS_W'(1);
          if (rem_q == BITS_W'(1))  state_q <= ST_IDLE;
          else if (wbits_q == 6'd1) state_q <= ST_FETCH;
          else                      state_q <= ST_LOW;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  mosi_mode0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sclk_o);

  // R1
  cs_release_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(done_o));

  // R9
  sclk_under_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
endmodule

// File: rtl/lbspi_master.sv
`timescale 1ns/1ps
module lbspi_master
  import lbspi_pkg::*;
#(
  parameter  int unsigned LEN_W      = 11,
  parameter  int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        reg_re_i,
  output logic [31:0] reg_rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no,
  output logic        irq_o
);
  logic [LEN_W-1:0]  len_q;
  logic              loop_q, irqen_q, done_q, ovr_q;
  logic              ctrl_wr, stat_wr, eng_start, eng_done, eng_busy;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [WORD_W-1:0] tx_word, rx_word, rx_head;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;

  assign ctrl_wr   = reg_we_i && (reg_addr_i == A_CTRL) && !eng_busy;
  assign stat_wr   = reg_we_i && (reg_addr_i == A_STAT);
  assign eng_start = ctrl_wr && reg_wdata_i[CTRL_START_BIT];
  assign tx_push   = reg_we_i && (reg_addr_i == A_TXDATA);
  assign rx_pop    = reg_re_i && (reg_addr_i == A_RXDATA);

  lbspi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push),
    .wdata_i (reg_wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_word),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .count_o (tx_cnt)
  );

  lbspi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .wdata_i (rx_word),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .count_o (rx_cnt)
  );

  lbspi_engine #(.LEN_W(LEN_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (eng_start),
    .len_i      (reg_wdata_i[LEN_W-1:0]),
    .loopback_i (loop_q),
    .miso_i     (miso_i),
    .tx_empty_i (tx_empty),
    .tx_word_i  (tx_word),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_word_o  (rx_word),
    .done_o     (eng_done),
    .busy_o     (eng_busy),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_no      (cs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      loop_q  <= 1'b0;
      irqen_q <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        len_q   <= reg_wdata_i[LEN_W-1:0];
        loop_q  <= reg_wdata_i[CTRL_LOOP_BIT];
        irqen_q <= reg_wdata_i[CTRL_IRQEN_BIT];
      end
      // completion beats a coincident clear
      if (eng_done)                                  done_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_DONE_BIT]) done_q <= 1'b0;
      if (rx_push && rx_full)                        ovr_q  <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_OVR_BIT])  ovr_q  <= 1'b0;
    end
  end

  assign irq_o = done_q && irqen_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      A_CTRL: begin
        reg_rdata_o[LEN_W-1:0]      = len_q;
        reg_rdata_o[CTRL_START_BIT] = eng_busy;
        reg_rdata_o[CTRL_LOOP_BIT]  = loop_q;
        reg_rdata_o[CTRL_IRQEN_BIT] = irqen_q;
      end
      A_STAT: begin
        reg_rdata_o[STAT_DONE_BIT]   = done_q;
        reg_rdata_o[STAT_OVR_BIT]    = ovr_q;
        reg_rdata_o[STAT_TXFULL_BIT] = tx_full;
        reg_rdata_o[STAT_RXAVL_BIT]  = !rx_empty;
      end
      A_LEVEL: begin
        reg_rdata_o[CNT_W-1:0]                   = tx_cnt;
        reg_rdata_o[LVL_RX_LSB+CNT_W-1:LVL_RX_LSB] = rx_cnt;
      end
      A_RXDATA: reg_rdata_o = rx_head;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R3
  done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> (done_q && !eng_busy));

  // R5
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && irqen_q) |=> irq_o);

  // R6
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && reg_wdata_i[STAT_DONE_BIT] && !eng_done) |=> !done_q);

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> ovr_q);

  // R11
  ctrl_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy |=> ($stable(loop_q) && $stable(len_q) && $stable(irqen_q)));
endmodule

// File: tb/tb_lbspi_master.sv
`timescale 1ns/1ps
module tb_lbspi_master;
  localparam int LEN_W = 11;
  localparam int DEPTH = 64;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_LVL = 3'd2,
                         AD_TX = 3'd3, AD_RX = 3'd4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0, miso = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n, irq;

  always #2.5 clk = ~clk;

  lbspi_master #(.LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_re_i(re), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // serial line monitor, sampled mid-cycle
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  int   sclk_rises = 0, cs_releases = 0, mode_err = 0;
  bit   cap[$];

  always @(negedge clk) begin
    if (!prev_sclk && sclk) begin
      sclk_rises++;
      cap.push_back(mosi);
      if (mosi !== prev_mosi) mode_err++;
    end
    if (sclk && cs_n) mode_err++;
    if (!prev_cs && cs_n) cs_releases++;
    prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
  end

  task automatic clear_mon();
    sclk_rises = 0; cs_releases = 0; mode_err = 0;
    cap.delete();
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(int len, bit start, bit loop, bit irqen);
    logic [31:0] v = '0;
    v[LEN_W-1:0] = LEN_W'(len);
    v[16] = start; v[17] = loop; v[18] = irqen;
    return v;
  endfunction

  task automatic wait_idle(string tag);
    logic [31:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      reg_read(AD_CTRL, v);
      if (!v[16]) begin ok = 1'b1; break; end
    end
    check({tag, " R3 start bit self-clears"}, 32'(ok), 32'd1);
  endtask

  // one burst with full checking of the serial stream and receive data
  task automatic run_burst(string tag, int nbits, bit loop, bit miso_val,
                           logic [31:0] words[$]);
    int nw = (nbits + 31) / 32;
    int lead = nbits % 32;
    logic [31:0] v, mask, exp;
    int bad_bits = 0, idx = 0;
    miso = miso_val;
    foreach (words[i]) reg_write(AD_TX, words[i]);
    clear_mon();
    reg_write(AD_CTRL, ctrl_word(nbits - 1, 1'b1, loop, 1'b0));
    wait_idle(tag);
    reg_read(AD_STAT, v);
    check({tag, " R3 done flag"}, 32'(v[0]), 32'd1);
    check({tag, " R1 sclk rises"}, sclk_rises, nbits);
    check({tag, " R1 single cs release"}, cs_releases, 1);
    check({tag, " R9 mode 0 timing"}, mode_err, 0);
    reg_read(AD_LVL, v);
    check({tag, " R4 levels"}, v, {16'(nw), 16'd0});
    // R2: expected MSB-first stream, leftover bits of word 0 only
    foreach (words[i]) begin
      int nb = (i == 0 && lead != 0) ? lead : 32;
      for (int b = nb - 1; b >= 0; b--) begin
        if (idx >= cap.size() || cap[idx] !== words[i][b]) bad_bits++;
        idx++;
      end
    end
    check({tag, " R2 mosi bit order"}, bad_bits, 0);
    for (int i = 0; i < nw; i++) begin
      mask = (i == 0 && lead != 0) ? ((32'd1 << lead) - 32'd1) : 32'hFFFF_FFFF;
      exp  = loop ? (words[i] & mask) : (miso_val ? mask : 32'd0);
      reg_read(AD_RX, v);
      check({tag, " R4 rx word"}, v, exp);
    end
    reg_write(AD_STAT, 32'd1);
    reg_read(AD_STAT, v);
    check({tag, " R6 done cleared"}, 32'(v[0]), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] q[$];
    logic [31:0] big[$];

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cs_n", 32'(cs_n), 32'd1);
    check("R10 sclk", 32'(sclk), 32'd0);
    check("R10 irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(AD_CTRL, v); check("R10 ctrl", v, 32'd0);
    reg_read(AD_STAT, v); check("R10 stat", v, 32'd0);
    reg_read(AD_LVL, v);  check("R10 level", v, 32'd0);

    // 32n+1 lengths and others, loopback
    q = '{32'hABCD_EF01};
    run_burst("len1", 1, 1'b1, 1'b0, q);
    q = '{32'hFFFF_FFF1, 32'hAAAA_AAAA};
    run_burst("len33", 33, 1'b1, 1'b0, q);
    q = '{32'h0000_0001, 32'hAAAA_AAAA, 32'h5555_5555};
    run_burst("len65", 65, 1'b1, 1'b0, q);
    q = '{32'h0000_0001, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0};
    run_burst("len97", 97, 1'b1, 1'b0, q);
    q = '{32'h8000_0000, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0000_0001, 32'hFFFF_0000};
    run_burst("len129", 129, 1'b1, 1'b0, q);
    q = '{32'h1234_56C3, 32'h0BAD_CAFE};
    run_burst("len40", 40, 1'b1, 1'b0, q);
    q = '{32'h8421_1248};
    run_burst("len32", 32, 1'b1, 1'b0, q);
    // external line
    q = '{32'h0000_00A5, 32'h6969_9696};
    run_burst("ext40_hi", 40, 1'b0, 1'b1, q);
    q = '{32'h0000_0001, 32'h7777_1111};
    run_burst("ext33_lo", 33, 1'b0, 1'b0, q);

    // R5 interrupt follows done and enable
    reg_write(AD_TX, 32'h1);
    reg_write(AD_CTRL, ctrl_word(0, 1'b1, 1'b1, 1'b1));
    wait_idle("irq");
    check("R5 irq after done", 32'(irq), 32'd1);
    reg_write(AD_STAT, 32'd1);
    check("R5 irq after clear", 32'(irq), 32'd0);
    reg_read(AD_RX, v);
    check("R4 irq burst rx", v, 32'd1);

    // R6 clear lands on the completion edge: start at E0, done at E3
    reg_write(AD_TX, 32'h0);
    reg_write(AD_CTRL, ctrl_word(0, 1'b1, 1'b1, 1'b1));
    @(negedge clk);
    @(negedge clk);
    reg_write(AD_STAT, 32'd1);
    reg_read(AD_STAT, v);
    check("R6 set wins over clear", 32'(v[0]), 32'd1);
    check("R5 irq held on coincidence", 32'(irq), 32'd1);
    reg_write(AD_STAT, 32'd1);
    reg_read(AD_STAT, v);
    check("R6 later clear", 32'(v[0]), 32'd0);
    check("R5 irq dropped", 32'(irq), 32'd0);
    reg_read(AD_RX, v);

    // R11 control write during a burst is ignored
    reg_write(AD_TX, 32'h0000_0001);
    reg_write(AD_TX, 32'hC3C3_3C3C);
    clear_mon();
    reg_write(AD_CTRL, ctrl_word(32, 1'b1, 1'b1, 1'b0));
    reg_write(AD_CTRL, ctrl_word(0, 1'b1, 1'b0, 1'b1));
    wait_idle("lock");
    check("R11 burst length kept", sclk_rises, 33);
    reg_read(AD_CTRL, v);
    check("R11 ctrl fields kept", v, ctrl_word(32, 1'b0, 1'b1, 1'b0));
    reg_read(AD_LVL, v);
    check("R11 no second burst", v, {16'd2, 16'd0});
    reg_read(AD_RX, v); check("R11 rx word0", v, 32'h1);
    reg_read(AD_RX, v); check("R11 rx word1", v, 32'hC3C3_3C3C);
    reg_write(AD_STAT, 32'd1);

    // R7 transmit FIFO full, R8 receive overrun
    for (int i = 0; i < DEPTH + 1; i++) begin
      big.push_back(32'(i) * 32'h0101_0101 ^ 32'h5A00_00A5);
      reg_write(AD_TX, big[i]);
    end
    reg_read(AD_LVL, v);
    check("R7 tx level saturates", v, {16'd0, 16'(DEPTH)});
    reg_read(AD_STAT, v);
    check("R7 tx full flag", 32'(v[2]), 32'd1);
    reg_write(AD_CTRL, ctrl_word(DEPTH * 32 - 1, 1'b1, 1'b1, 1'b0));
    wait_idle("full");
    reg_read(AD_LVL, v);
    check("R7 tx drained rx full", v, {16'(DEPTH), 16'd0});
    reg_read(AD_STAT, v);
    check("R8 no overrun yet", 32'(v[1]), 32'd0);
    reg_write(AD_TX, 32'h1);
    reg_write(AD_CTRL, ctrl_word(0, 1'b1, 1'b1, 1'b0));
    wait_idle("ovr");
    reg_read(AD_STAT, v);
    check("R8 overrun set", 32'(v[1]), 32'd1);
    reg_read(AD_LVL, v);
    check("R8 rx level held", v, {16'(DEPTH), 16'd0});
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        reg_read(AD_RX, v);
        if (v !== big[i]) bad++;
      end
      check("R7 dropped word absent, order kept", bad, 0);
    end
    reg_write(AD_STAT, 32'd3);
    reg_read(AD_STAT, v);
    check("R8 overrun cleared", v, 32'd0);

    summary();
    $finish;
  end
endmodule